// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Block

This block collects completion and fault events from a set of DMA channel engines into one shared register window. Each channel reports four kinds of event: transfer done, source fault, destination fault and configuration fault. A single-cycle pulse on an event input latches a sticky bit for that channel and class. Software sees each class in two views: a raw view with every latched bit, and a masked view in which only the bits whose channel has the matching interrupt enable are visible.

Software finds pending work by reading the masked views. It acknowledges events by writing a channel bit mask to a raw view. A 1 clears that channel's bit, and a 0 leaves it alone. To abort a channel, software writes that channel's bit to all four raw views. One interrupt line stays high while any masked bit is set. A read-only word shows the live busy state of every channel, and software must not restart a channel while its busy bit is set. Two plain storage words hold a group priority setting and an arbitration setting for the channel engines. An arbitration value of 0 means all channels have equal priority.

Top module: `dma_evt_status`

## Requirements
- R1: After reset all raw and masked bits are 0, `irq` is 0, and `prio_cfg` and `arb_cfg` are 0.
- R2: A pulse on bit i of an event input sets bit i of that class's raw word. Bit i of every event word belongs to channel i. The bit stays set until it is cleared, and the other bits do not change.
- R3: The raw words are at 0x810 (done), 0x814 (source fault), 0x818 (destination fault) and 0x81C (configuration fault). Writing a mask to a raw word clears the bits where the mask is 1 and keeps the bits where it is 0, so writing all ones clears every channel.
- R4: The masked words are at 0x800, 0x804, 0x808 and 0x80C, in the same class order as the raw words. The done class is masked by `ie_done`, and the three fault classes are masked by `ie_err`.
- R5: `irq` is 1 exactly when at least one bit of the four masked words is set. It rises in the cycle after the event edge and falls in the cycle after the clearing write.
- R6: If an event arrives in the same cycle as a write that clears the same bit, the bit ends up set.
- R7: Reading 0x820 returns `ch_active` in bits NCH-1:0 in the same cycle.
- R8: Writes to the masked words or to the busy word have no effect, and reads from any unmapped address return 0.
- R9: The word at 0x824 is stored into `prio_cfg` and the word at 0x828 into `arb_cfg`. Both read back what was written, and the new value appears in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_done | input | NCH | Per-channel transfer-done pulses |
| evt_src_err | input | NCH | Per-channel source-fault pulses |
| evt_dst_err | input | NCH | Per-channel destination-fault pulses |
| evt_cfg_err | input | NCH | Per-channel configuration-fault pulses |
| ch_active | input | NCH | Live busy state of each channel |
| ie_done | input | NCH | Per-channel enable for the done class |
| ie_err | input | NCH | Per-channel enable for the three fault classes |
| reg_addr | input | AW | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt |
| prio_cfg | output | DW | Stored group priority word |
| arb_cfg | output | DW | Stored arbitration word (0 means equal priority) |

## Verification
A new event and a software clear of the same raw bit can happen in the same clock cycle. In that case the event must win, and the bits in the clear mask that have no event must still clear. The bench provokes this for every class and every channel. It writes an all-ones clear to a raw word while it pulses one channel's event in that same cycle. It then reads the word back and expects only that channel's bit to remain set, with `irq` still high when that bit's enable is on.

// File: rtl/dma_evt_status.sv
module dma_evt_status #(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_done,
  input  logic [NCH-1:0] evt_src_err,
  input  logic [NCH-1:0] evt_dst_err,
  input  logic [NCH-1:0] evt_cfg_err,
  input  logic [NCH-1:0] ch_active,
  input  logic [NCH-1:0] ie_done,
  input  logic [NCH-1:0] ie_err,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_wr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           irq,
  output logic [DW-1:0]  prio_cfg,
  output logic [DW-1:0]  arb_cfg
);
  localparam int NCLS = 4;
  localparam logic [AW-1:0] A_MSK  = AW'(12'h800);
  localparam logic [AW-1:0] A_RAW  = AW'(12'h810);
  localparam logic [AW-1:0] A_BUSY = AW'(12'h820);
  localparam logic [AW-1:0] A_PRIO = AW'(12'h824);
  localparam logic [AW-1:0] A_ARB  = AW'(12'h828);

  logic [NCLS-1:0][NCH-1:0] evt_all, en_all, raw_all, msk_all;

  assign evt_all = {evt_cfg_err, evt_dst_err, evt_src_err, evt_done};
  assign en_all  = {ie_err, ie_err, ie_err, ie_done};

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    logic [NCH-1:0] raw_q;
    logic [NCH-1:0] clr;
    logic           hit;

    assign hit = reg_wr && (reg_addr == A_RAW + AW'(4 * k));
    assign clr = hit ? reg_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & ~clr) | evt_all[k];
    end

    assign raw_all[k] = raw_q;
    assign msk_all[k] = raw_q & en_all[k];

    // R6
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_all[k]) |=> ((raw_all[k] & $past(evt_all[k])) == $past(evt_all[k])));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && evt_all[k] == '0) |=> ((raw_all[k] & $past(reg_wdata[NCH-1:0])) == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && evt_all[k] == '0) |=> $stable(raw_all[k]));
  end

  assign irq = |msk_all;

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_all == '0) |-> !irq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_cfg <= '0;
      arb_cfg  <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_PRIO) prio_cfg <= reg_wdata;
      if (reg_addr == A_ARB)  arb_cfg  <= reg_wdata;
    end
  end

  // R9
  arb_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ARB) |=> (arb_cfg == $past(reg_wdata)));

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (reg_addr == A_MSK + AW'(4 * k)) reg_rdata[NCH-1:0] = msk_all[k];
      if (reg_addr == A_RAW + AW'(4 * k)) reg_rdata[NCH-1:0] = raw_all[k];
    end
    if (reg_addr == A_BUSY) reg_rdata[NCH-1:0] = ch_active;
    if (reg_addr == A_PRIO) reg_rdata = prio_cfg;
    if (reg_addr == A_ARB)  reg_rdata = arb_cfg;
  end
endmodule

// File: tb/dma_evt_status_test.sv
module dma_evt_status_test;
  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int DW  = 32;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] evt_done = 0, evt_src_err = 0, evt_dst_err = 0, evt_cfg_err = 0;
  logic [NCH-1:0] ch_active = 0, ie_done = 0, ie_err = 0;
  logic [AW-1:0]  reg_addr = 0;
  logic           reg_wr = 0;
  logic [DW-1:0]  reg_wdata = 0;
  logic [DW-1:0]  reg_rdata, prio_cfg, arb_cfg;
  logic           irq;

  int tests = 0, fails = 0;
  logic [NCH-1:0] exp_raw [4];

  always #4 clk = ~clk;

  dma_evt_status #(.NCH(NCH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .evt_done(evt_done), .evt_src_err(evt_src_err),
    .evt_dst_err(evt_dst_err), .evt_cfg_err(evt_cfg_err),
    .ch_active(ch_active), .ie_done(ie_done), .ie_err(ie_err),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .prio_cfg(prio_cfg), .arb_cfg(arb_cfg)
  );

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_evt(int k, logic [NCH-1:0] v);
    case (k)
      0: evt_done = v;
      1: evt_src_err = v;
      2: evt_dst_err = v;
      default: evt_cfg_err = v;
    endcase
  endtask

  // one clock with an optional write and optional event on class ek
  task automatic cycle(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, int ek, logic [NCH-1:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    if (ek >= 0) set_evt(ek, ev);
    @(negedge clk);
    reg_wr = 0;
    evt_done = 0; evt_src_err = 0; evt_dst_err = 0; evt_cfg_err = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [NCH-1:0] en_of(int k);
    return (k == 0) ? ie_done : ie_err;
  endfunction

  function automatic logic exp_irq();
    logic r = 0;
    for (int k = 0; k < 4; k++) r |= |(exp_raw[k] & en_of(k));
    return r;
  endfunction

  initial begin
    #(8 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    for (int k = 0; k < 4; k++) exp_raw[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1
    for (int k = 0; k < 4; k++) begin
      rd(AW'(12'h810 + 4*k), v); chk("R1 raw reset", v, 0);
      rd(AW'(12'h800 + 4*k), v); chk("R1 masked reset", v, 0);
    end
    chk("R1 irq reset", {31'd0, irq}, 0);
    chk("R1 prio reset", prio_cfg, 0);
    chk("R1 arb reset", arb_cfg, 0);

    // R2: set each channel of each class in turn
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < NCH; i++) begin
        cycle(0, 0, 0, k, NCH'(1 << i));
        exp_raw[k] |= NCH'(1 << i);
        rd(AW'(12'h810 + 4*k), v); chk("R2 raw set", v, DW'(exp_raw[k]));
        for (int j = 0; j < 4; j++) if (j != k) begin
          rd(AW'(12'h810 + 4*j), v); chk("R2 other class kept", v, DW'(exp_raw[j]));
        end
      end

    // R4 / R5: sweep enable patterns with all raw bits set
    for (int p = 0; p < 16; p++) begin
      ie_done = NCH'(p); ie_err = NCH'(~p);
      #1;
      for (int k = 0; k < 4; k++) begin
        rd(AW'(12'h800 + 4*k), v);
        chk("R4 masked view", v, DW'(exp_raw[k] & en_of(k)));
      end
      chk("R5 irq with enables", {31'd0, irq}, {31'd0, exp_irq()});
    end

    // R8: writes to masked and busy words change nothing
    ie_done = '1; ie_err = '1;
    for (int k = 0; k < 4; k++) cycle(1, AW'(12'h800 + 4*k), '1, -1, 0);
    cycle(1, AW'(12'h820), '1, -1, 0);
    for (int k = 0; k < 4; k++) begin
      rd(AW'(12'h810 + 4*k), v); chk("R8 masked write ignored", v, DW'(exp_raw[k]));
    end
    rd(AW'(12'h830), v); chk("R8 unmapped read", v, 0);
    rd(AW'(12'h7FC), v); chk("R8 unmapped read low", v, 0);

    // R3: partial clears with sweep of masks
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 16; p++) begin
        cycle(0, 0, 0, k, '1);
        exp_raw[k] = '1;
        cycle(1, AW'(12'h810 + 4*k), DW'(p), -1, 0);
        exp_raw[k] &= ~NCH'(p);
        rd(AW'(12'h810 + 4*k), v); chk("R3 write-one-to-clear", v, DW'(exp_raw[k]));
      end

    // R3: all-ones clear everywhere (channel abort style)
    for (int k = 0; k < 4; k++) begin
      cycle(1, AW'(12'h810 + 4*k), '1, -1, 0);
      exp_raw[k] = 0;
      rd(AW'(12'h810 + 4*k), v); chk("R3 clear all", v, 0);
    end
    chk("R5 irq low after clears", {31'd0, irq}, 0);

    // R5: irq rises from a single enabled event, falls on its clear
    ie_done = 4'b0100; ie_err = 0;
    cycle(0, 0, 0, 1, 4'b0001);
    exp_raw[1] = 4'b0001;
    chk("R5 disabled fault no irq", {31'd0, irq}, 0);
    cycle(0, 0, 0, 0, 4'b0100);
    exp_raw[0] = 4'b0100;
    chk("R5 irq rises", {31'd0, irq}, 1);
    cycle(1, AW'(12'h810), 32'h4, -1, 0);
    exp_raw[0] = 0;
    chk("R5 irq falls", {31'd0, irq}, 0);
    cycle(1, AW'(12'h814), '1, -1, 0);
    exp_raw[1] = 0;

    // R6: event in the same cycle as an all-ones clear
    ie_done = '1; ie_err = '1;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < NCH; i++) begin
        cycle(0, 0, 0, k, '1);
        cycle(1, AW'(12'h810 + 4*k), '1, k, NCH'(1 << i));
        exp_raw[k] = NCH'(1 << i);
        rd(AW'(12'h810 + 4*k), v); chk("R6 event beats clear", v, DW'(exp_raw[k]));
        chk("R6 irq kept", {31'd0, irq}, 1);
        cycle(1, AW'(12'h810 + 4*k), '1, -1, 0);
        exp_raw[k] = 0;
      end

    // R7: busy word is live
    for (int p = 0; p < 16; p++) begin
      ch_active = NCH'(p);
      rd(AW'(12'h820), v); chk("R7 busy live", v, DW'(p));
    end
    ch_active = 0;

    // R9: priority and arbitration storage
    for (int p = 0; p < 4; p++) begin
      logic [DW-1:0] a, b;
      a = 32'h1234_5678 ^ DW'(p * 32'h0101_0101);
      b = ~a;
      cycle(1, AW'(12'h824), a, -1, 0);
      cycle(1, AW'(12'h828), b, -1, 0);
      chk("R9 prio output", prio_cfg, a);
      chk("R9 arb output", arb_cfg, b);
      rd(AW'(12'h824), v); chk("R9 prio readback", v, a);
      rd(AW'(12'h828), v); chk("R9 arb readback", v, b);
    end
    cycle(1, AW'(12'h828), 0, -1, 0);
    chk("R9 arb equal priority value", arb_cfg, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule